// File: doc/BRIEF.md
# Pipelined Carry-Save Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits each and returns the full product. It does not use a behavioural multiply operator. It builds one partial-product row for each bit of the second operand. Layers of 3:2 carry-save compressors then shrink that stack of rows. In each layer, every full adder passes its carry only into the next higher-weight column. Once two rows remain, one ripple carry-propagate adder combines them. This final adder is the only place where a carry can travel the full width.

The work is divided into three register stages:

- **Stage 1:** row generation and the first half of the compressor layers.
- **Stage 2:** the remaining compressor layers, down to two rows.
- **Stage 3:** the carry-propagate addition.

A valid flag travels with the data through every stage. The block accepts a new operand pair on every clock and presents the product a fixed three cycles later. It is meant to be replicated per lane, or placed in front of a summing tree, where a known latency and full throughput matter more than the smallest area.

Top module: `wt_mult`

## Requirements
- R1: When `res_vld` is high, `res_prod` equals `opnd_a` × `opnd_b`, treated as unsigned, for the pair accepted with it. With the default width this holds for all 65536 pairs, and the largest value is 65025 (255 × 255).
- R2: `res_prod` is 2·`W`+1 bits wide. Its most significant bit is a guard bit that is 0 whenever `res_vld` is high.
- R3: `res_vld` is high exactly three rising edges after `in_vld` was sampled high. The product of that pair is on `res_prod` in the same cycle.
- R4: A new operand pair is accepted on every clock edge where `in_vld` is high. Back-to-back pairs come out in order, one per cycle, with no gaps.
- R5: A cycle with `in_vld` low produces a cycle with `res_vld` low three edges later. Bubbles keep their position in the stream.
- R6: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears every stage's valid flag. `res_vld` is low from that edge on, even if valid pairs were in flight.
- R7: Each compressor layer conserves the arithmetic value of its rows. The rows held after stage 1, summed modulo 2^(2W+1), equal the product of the pair that produced them.
- R8: Full-width carry propagation happens only in stage 3. Stage 2 stores exactly two rows, and their sum equals the value held after stage 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid flags |
| in_vld | input | 1 | Operand pair on `opnd_a`/`opnd_b` is to be multiplied |
| opnd_a | input | W | Unsigned multiplicand |
| opnd_b | input | W | Unsigned multiplier; bit i selects partial-product row i |
| res_vld | output | 1 | `res_prod` holds a product |
| res_prod | output | 2W+1 | Unsigned product with guard bit on top |

## Verification
The bench builds the block with its default `W` = 8. At this width the whole 65536-pair operand space can be swept back to back in one stream, so every column pattern of the compressor layers is exercised. That includes the all-ones case that produces the largest product and the longest carry chain in the final adder. A short directed phase at the same width adds the corner pairs, interleaved bubbles, and a reset while the pipeline is full. These show the latency, the preserved bubble positions and the clearing of the valid flags at the ports.

// File: rtl/wt_pkg.sv
// Package wt_pkg
// Purpose : constant functions that size the carry-save reduction.
// Assumes : row counts are small positive integers known at elaboration.
package wt_pkg;

    // Row count after one 3:2 layer: each full group of three rows becomes two.
    function automatic int rows_next(input int n);
        return n - (n / 3);
    endfunction

    // Row count after k layers, starting from n rows.
    function automatic int rows_after(input int n, input int k);
        int r;
        r = n;
        for (int i = 0; i < k; i++) r = rows_next(r);
        return r;
    endfunction

    // Number of layers needed to bring n rows down to two.
    function automatic int layers_to_two(input int n);
        int r;
        int c;
        r = n;
        c = 0;
        while (r > 2) begin
            r = rows_next(r);
            c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/fa_cell.sv
// Module fa_cell
// Purpose : one-bit full adder (3:2 compressor).
// Assumes : purely combinational; carry goes to the next higher column.
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic axb;

    // Sum and majority carry.
    always_comb begin
        axb = a ^ b;
        s   = axb ^ ci;
        co  = (a & b) | (ci & axb);
    end
endmodule

// File: rtl/ha_cell.sv
// Module ha_cell
// Purpose : one-bit half adder, used at the bottom of the ripple adder.
// Assumes : purely combinational.
module ha_cell (
    input  logic a,
    input  logic b,
    output logic s,
    output logic co
);
    // Sum and carry of two bits.
    always_comb begin
        s  = a ^ b;
        co = a & b;
    end
endmodule

// File: rtl/csa_row.sv
// Module csa_row
// Purpose : compresses three PW-bit rows into a sum row and a carry row.
//           Each column uses one full adder, and its carry moves to the
//           next column only.
// Assumes : arithmetic is modulo 2^PW; a carry out of the top column is
//           dropped (the operands never produce one).
module csa_row #(
    parameter int PW = 17
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    input  logic [PW-1:0] z,
    output logic [PW-1:0] s,
    output logic [PW-1:0] c
);
    logic [PW-2:0] co;

    genvar k;
    generate
        for (k = 0; k < PW - 1; k++) begin : g_col
            fa_cell u_fa (
                .a  (x[k]),
                .b  (y[k]),
                .ci (z[k]),
                .s  (s[k]),
                .co (co[k])
            );
        end
    endgenerate

    // Top column: sum bit only, since its carry leaves the word.
    assign s[PW-1] = x[PW-1] ^ y[PW-1] ^ z[PW-1];
    // Carry row is the column carries moved up by one weight.
    assign c = {co, 1'b0};
endmodule

// File: rtl/csa_layers.sv
// Module csa_layers
// Purpose : NL consecutive layers of 3:2 compression.
//           Rows are taken in groups of three from the top of the stack;
//           rows left over pass through unchanged.
// Assumes : NOUT equals wt_pkg::rows_after(NIN, NL); unused row slots
//           are held at zero.
module csa_layers #(
    parameter int PW   = 17,
    parameter int NIN  = 8,
    parameter int NL   = 2,
    parameter int NOUT = 4
) (
    input  logic [NIN-1:0][PW-1:0]  rows_i,
    output logic [NOUT-1:0][PW-1:0] rows_o
);
    logic [NIN-1:0][PW-1:0] lvl [0:NL];

    assign lvl[0] = rows_i;

    genvar l, g, r;
    generate
        for (l = 0; l < NL; l++) begin : g_lay
            localparam int CUR = wt_pkg::rows_after(NIN, l);
            localparam int GRP = CUR / 3;
            localparam int NXT = CUR - GRP;
            for (g = 0; g < GRP; g++) begin : g_grp
                csa_row #(.PW(PW)) u_csa (
                    .x (lvl[l][3*g]),
                    .y (lvl[l][3*g+1]),
                    .z (lvl[l][3*g+2]),
                    .s (lvl[l+1][2*g]),
                    .c (lvl[l+1][2*g+1])
                );
            end
            for (r = 2 * GRP; r < NIN; r++) begin : g_pass
                if (r < NXT) begin : g_fwd
                    assign lvl[l+1][r] = lvl[l][r+GRP];
                end else begin : g_zero
                    assign lvl[l+1][r] = '0;
                end
            end
        end
    endgenerate

    assign rows_o = lvl[NL][NOUT-1:0];
endmodule

// File: rtl/cpa_ripple.sv
// Module cpa_ripple
// Purpose : final carry-propagate adder joining the last two rows.
//           This is the only full-width carry chain in the multiplier.
// Assumes : result is modulo 2^PW; PW >= 3.
module cpa_ripple #(
    parameter int PW = 17
) (
    input  logic [PW-1:0] a,
    input  logic [PW-1:0] b,
    output logic [PW-1:0] sum
);
    logic [PW-1:1] cy;

    ha_cell u_ha0 (
        .a  (a[0]),
        .b  (b[0]),
        .s  (sum[0]),
        .co (cy[1])
    );

    genvar k;
    generate
        for (k = 1; k < PW - 1; k++) begin : g_bit
            fa_cell u_fa (
                .a  (a[k]),
                .b  (b[k]),
                .ci (cy[k]),
                .s  (sum[k]),
                .co (cy[k+1])
            );
        end
    endgenerate

    // Top bit: sum only.
    assign sum[PW-1] = a[PW-1] ^ b[PW-1] ^ cy[PW-1];
endmodule

// File: rtl/wt_mult.sv
// Module wt_mult
// Purpose : unsigned W x W multiplier with a three-stage pipeline.
//           Stage 1 builds the partial-product rows and runs the first
//           compressor layers, stage 2 finishes compression to two rows,
//           and stage 3 is the carry-propagate add. One pair per clock.
// Assumes : synchronous active-low reset clears only the valid flags;
//           data registers load freely and are qualified by valid.
module wt_mult #(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    output logic            res_vld,
    output logic [2*W:0]    res_prod
);
    localparam int PW     = 2 * W + 1;
    localparam int NL_ALL = wt_pkg::layers_to_two(W);
    localparam int NL1    = (NL_ALL + 1) / 2;
    localparam int NL2    = NL_ALL - NL1;
    localparam int R1     = wt_pkg::rows_after(W, NL1);
    localparam logic [PW-1:0] PMAX = PW'(((2 ** W) - 1) * ((2 ** W) - 1));

    logic [W-1:0][PW-1:0]  pp;
    logic [R1-1:0][PW-1:0] l1_rows;
    logic [R1-1:0][PW-1:0] s1_rows;
    logic [1:0][PW-1:0]    l2_rows;
    logic [1:0][PW-1:0]    s2_rows;
    logic [PW-1:0]         cpa_sum;
    logic                  v1, v2;

    // Partial-product rows: A gated by bit i of B, moved up i places.
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pp
            assign pp[i] = PW'(opnd_a & {W{opnd_b[i]}}) << i;
        end
    endgenerate

    csa_layers #(.PW(PW), .NIN(W), .NL(NL1), .NOUT(R1)) u_lay1 (
        .rows_i (pp),
        .rows_o (l1_rows)
    );

    csa_layers #(.PW(PW), .NIN(R1), .NL(NL2), .NOUT(2)) u_lay2 (
        .rows_i (s1_rows),
        .rows_o (l2_rows)
    );

    cpa_ripple #(.PW(PW)) u_cpa (
        .a   (s2_rows[0]),
        .b   (s2_rows[1]),
        .sum (cpa_sum)
    );

    // Data pipeline registers, unreset and qualified by the valid flags.
    always_ff @(posedge clk) begin
        s1_rows  <= l1_rows;
        s2_rows  <= l2_rows;
        res_prod <= cpa_sum;
    end

    // Valid flags travel with the data; reset empties the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1      <= 1'b0;
            v2      <= 1'b0;
            res_vld <= 1'b0;
        end else begin
            v1      <= in_vld;
            v2      <= v1;
            res_vld <= v2;
        end
    end

    // ---------------- assertions ----------------
    logic [1:0] since_rst;

    // Counts edges since reset so the latency check only looks back over cycles after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    function automatic logic [PW-1:0] sum_s1(input logic [R1-1:0][PW-1:0] r);
        logic [PW-1:0] acc;
        acc = '0;
        for (int k = 0; k < R1; k++) acc = acc + r[k];
        return acc;
    endfunction

    // R1
    prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_prod <= PMAX));
    // R2
    guard_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> !res_prod[PW-1]);
    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (res_vld == $past(in_vld, 3)));
    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && !v1 && !v2));
    // R7
    stage1_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v1 |-> (sum_s1(s1_rows) == $past(PW'(opnd_a) * PW'(opnd_b))));
    // R8
    stage2_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> ((s2_rows[0] + s2_rows[1]) == $past(sum_s1(s1_rows))));
    // R8
    cpa_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_prod == $past(s2_rows[0] + s2_rows[1])));
endmodule

// File: tb/sim_wt_mult.sv
module sim_wt_mult;
    localparam int W  = 8;
    localparam int PW = 2 * W + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic          res_vld;
    logic [PW-1:0] res_prod;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // History of the three most recent drives; index 2 is due at the output now.
    logic          h_v [0:2];
    logic [W-1:0]  h_a [0:2];
    logic [W-1:0]  h_b [0:2];
    string         h_t [0:2];

    wt_mult #(.W(W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .res_vld  (res_vld),
        .res_prod (res_prod)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 200000);
            finish_run();
        end
    end

    task automatic clear_hist();
        for (int k = 0; k < 3; k++) begin
            h_v[k] = 1'b0; h_a[k] = '0; h_b[k] = '0; h_t[k] = "idle";
        end
    endtask

    // Compares the outputs against the pair driven three negedges ago.
    task automatic check_out();
        logic [PW-1:0] exp;
        n_chk++;
        if (res_vld !== h_v[2]) begin
            n_bad++;
            $display("FAIL R3/R5 (%s): res_vld=%b expected %b", h_t[2], res_vld, h_v[2]);
        end
        if (h_v[2]) begin
            exp = PW'(h_a[2]) * PW'(h_b[2]);
            n_chk++;
            if (res_prod !== exp) begin
                n_bad++;
                $display("FAIL R1/R4/R7/R8 (%s) %0d*%0d: res_prod=%0d expected %0d",
                         h_t[2], h_a[2], h_b[2], res_prod, exp);
            end
            n_chk++;
            if (res_prod[PW-1] !== 1'b0) begin
                n_bad++;
                $display("FAIL R2 (%s): guard=%b expected 0", h_t[2], res_prod[PW-1]);
            end
        end
    endtask

    // One cycle: check the output due now, then drive the next input.
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag);
        @(negedge clk);
        check_out();
        for (int k = 2; k > 0; k--) begin
            h_v[k] = h_v[k-1]; h_a[k] = h_a[k-1]; h_b[k] = h_b[k-1]; h_t[k] = h_t[k-1];
        end
        h_v[0] = v; h_a[0] = a; h_b[0] = b; h_t[0] = tag;
        in_vld = v; opnd_a = a; opnd_b = b;
    endtask

    initial begin
        clear_hist();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R6: reset state
        n_chk++;
        if (res_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 reset: res_vld=%b expected 0", res_vld);
        end
        rst_n = 1'b1;

        // R1 R2 corners, with bubbles between them for R3 and R5
        step(1'b1, 8'd0,   8'd0,   "R1 corner 0x0");
        step(1'b1, 8'd255, 8'd255, "R1 R2 corner 255x255");
        step(1'b0, 8'd77,  8'd99,  "R5 bubble");
        step(1'b1, 8'd255, 8'd1,   "R1 corner 255x1");
        step(1'b0, 8'd0,   8'd0,   "R5 bubble");
        step(1'b0, 8'd0,   8'd0,   "R5 bubble");
        step(1'b1, 8'd128, 8'd2,   "R1 corner 128x2");
        step(1'b1, 8'd1,   8'd255, "R1 corner 1x255");
        for (int k = 0; k < 40; k++)
            step(k[0], 8'(k * 37 + 11), 8'(k * 53 + 5), "R5 alternating valid");
        for (int k = 0; k < 3; k++) step(1'b0, '0, '0, "R3 drain");

        // R6: reset while the pipe is full
        for (int k = 0; k < 3; k++) step(1'b1, 8'(k + 200), 8'(k + 3), "R4 fill");
        @(negedge clk);
        rst_n = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);
        n_chk++;
        if (res_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 mid-stream reset: res_vld=%b expected 0", res_vld);
        end
        @(negedge clk);
        n_chk++;
        if (res_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 held reset: res_vld=%b expected 0", res_vld);
        end
        clear_hist();
        rst_n = 1'b1;

        // R1 R4 R7 R8: all pairs back to back
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(1'b1, 8'(a), 8'(b), "R1 R4 sweep");
        for (int k = 0; k < 4; k++) step(1'b0, '0, '0, "R3 drain");

        finish_run();
    end
endmodule